// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel samples. The stream has three lines: a bit clock, a frame clock that marks which channel is being sent, and a data line. All three are oversampled in the system clock domain, so the bit clock must be several times slower than the system clock. A 2-bit format select picks one of four framings. Two are front-aligned: left-justified and I2S. Two are aligned to the end of the half-frame: right-justified with 16-bit words and right-justified with 24-bit words.

Each channel word is assembled in its own half-frame and completes when the frame clock changes level. A finished left word is held. It is released, together with the right word that follows it, as one sample pair on a single-cycle strobe. A right word that has no held left word in front of it is discarded. Because of this, left/right pairs leave together, and a right/left ordering never forms a pair.

Top module: `ser_audio_rx`

## Requirements
- R1: While reset is high, and after it, until the first pair is released, `pair_valid_o` is 0 and `left_o` and `right_o` are 0.
- R2: With format 00 (left-justified), the left channel is the frame clock's high phase and the MSB is the bit sampled on the first bit-clock rise of the half-frame.
- R3: With format 01 (I2S), the left channel is the frame clock's low phase and the MSB is the bit sampled on the second bit-clock rise of the half-frame.
- R4: With format 11 (right-justified 24), the left channel is the frame clock's high phase and the word is the last 24 bits sampled before the frame clock changes, the final one being the LSB.
- R5: With format 10 (right-justified 16), the word is the last 16 bits sampled before the frame clock changes, sign-extended from bit 15 into bits 23:16.
- R6: Data is two's complement, sent MSB first, and sampled at the rising edges of the bit clock.
- R7: In formats 00 and 01, a half-frame that carries fewer than 24 data bits gives a word left-aligned at bit 23, with zeros below the last received bit.
- R8: In formats 00 and 01, bits after the 24th data bit of a half-frame do not change the word.
- R9: `pair_valid_o` is a one-cycle pulse, `left_o`/`right_o` change only in the cycle it is high, and each pulse carries a left word with the right word that came right after it.
- R10: A right word that is not preceded by a completed left word is dropped, and the partial half-frame seen first after reset never yields a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 2 | Framing select: 00 left-justified, 01 I2S, 10 right-justified 16, 11 right-justified 24 |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| lrclk_i | input | 1 | Frame clock that selects the channel (asynchronous) |
| sdata_i | input | 1 | Serial data line (asynchronous) |
| left_o | output | 24 | Left sample of the last released pair |
| right_o | output | 24 | Right sample of the last released pair |
| pair_valid_o | output | 1 | One-cycle strobe that marks a new pair |

## Verification
The hardest situation to reach from the ports is an orphan right word: a full right half-frame that arrives after the receiver has locked to the frame clock but with no held left word. The bench reaches it by starting one run with a left half-frame, which only primes the edge detector, followed by a full right half-frame. It then checks that the released pair count and the first pair match only the left/right pairs that follow. Junk bits are placed outside the data window in every half-frame. Shortened half-frames exercise the left-aligned zero fill.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    FMT_LJ   = 2'b00,
    FMT_I2S  = 2'b01,
    FMT_RJ16 = 2'b10,
    FMT_RJ24 = 2'b11
  } fmt_e;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic lrclk_i,
  input  logic sdata_i,
  output logic rise_o,
  output logic lr_o,
  output logic dat_o
);

  localparam int W = 3;

  logic [STAGES-1:0][W-1:0] stg_q;
  logic                     bclk_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q    <= '0;
      bclk_d_q <= 1'b0;
    end else begin
      stg_q[0] <= {sdata_i, lrclk_i, bclk_i};
      for (int k = 1; k < STAGES; k++) begin
        stg_q[k] <= stg_q[k-1];
      end
      bclk_d_q <= stg_q[STAGES-1][0];
    end
  end

  assign rise_o = stg_q[STAGES-1][0] & ~bclk_d_q;
  assign lr_o   = stg_q[STAGES-1][1];
  assign dat_o  = stg_q[STAGES-1][2];

  // R6: a rising bit-clock edge is seen for one system cycle only
  p_single_rise_r6: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/sar_frame.sv
module sar_frame #(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  sar_pkg::fmt_e   fmt_i,
  input  logic            rise_i,
  input  logic            lr_i,
  input  logic            dat_i,
  output logic            done_o,
  output logic            done_left_o,
  output logic [SAMPLE_W-1:0] word_o
);
  import sar_pkg::*;

  localparam int IDX_W = $clog2(SAMPLE_W + 2) + 1;
  localparam int EXT_W = SAMPLE_W - SHORT_W;

  logic                seen_q, primed_q, lr_q;
  logic [IDX_W-1:0]    idx_q;
  logic [SAMPLE_W-1:0] acc_q, shr_q;

  logic                edge_hit, left_prev, in_win;
  logic [IDX_W-1:0]    idx_cur, off, pos, idx_next;
  logic [SAMPLE_W-1:0] acc_n, finished;

  always_comb begin
    edge_hit  = seen_q && (lr_i != lr_q);
    idx_cur   = edge_hit ? '0 : idx_q;
    off       = (fmt_i == FMT_I2S) ? IDX_W'(1) : '0;
    pos       = idx_cur - off;
    in_win    = (idx_cur >= off) && (pos < IDX_W'(SAMPLE_W));
    idx_next  = (&idx_cur) ? idx_cur : idx_cur + IDX_W'(1);
    acc_n     = edge_hit ? '0 : acc_q;
    for (int j = 0; j < SAMPLE_W; j++) begin
      if (in_win && pos == IDX_W'(j)) acc_n[SAMPLE_W-1-j] = dat_i;
    end
    left_prev = (fmt_i == FMT_I2S) ? ~lr_q : lr_q;
    case (fmt_i)
      FMT_RJ24: finished = shr_q;
      FMT_RJ16: finished = {{EXT_W{shr_q[SHORT_W-1]}}, shr_q[SHORT_W-1:0]};
      default:  finished = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q      <= 1'b0;
      primed_q    <= 1'b0;
      lr_q        <= 1'b0;
      idx_q       <= '0;
      acc_q       <= '0;
      shr_q       <= '0;
      done_o      <= 1'b0;
      done_left_o <= 1'b0;
      word_o      <= '0;
    end else begin
      done_o <= 1'b0;
      if (rise_i) begin
        seen_q <= 1'b1;
        lr_q   <= lr_i;
        idx_q  <= idx_next;
        acc_q  <= acc_n;
        shr_q  <= {shr_q[SAMPLE_W-2:0], dat_i};
        if (edge_hit) begin
          primed_q <= 1'b1;
          if (primed_q) begin
            done_o      <= 1'b1;
            done_left_o <= left_prev;
            word_o      <= finished;
          end
        end
      end
    end
  end

  // R9: completed words are single-cycle events
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10: no word before the receiver has locked onto a frame edge
  p_no_partial_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(primed_q));

  // R5: a short right-justified word leaves sign-extended
  p_rj16_sext_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && fmt_i == FMT_RJ16) |->
      (word_o[SAMPLE_W-1:SHORT_W] == {EXT_W{word_o[SHORT_W-1]}}));

endmodule

// File: rtl/sar_pair.sv
module sar_pair #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                done_i,
  input  logic                done_left_i,
  input  logic [SAMPLE_W-1:0] word_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  logic [SAMPLE_W-1:0] hold_q;
  logic                pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      pend_q  <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done_i) begin
        if (done_left_i) begin
          hold_q <= word_i;
          pend_q <= 1'b1;
        end else if (pend_q) begin
          left_o  <= hold_q;
          right_o <= word_i;
          valid_o <= 1'b1;
          pend_q  <= 1'b0;
        end
      end
    end
  end

  // R9: a right word behind a held left word releases the pair
  p_pair_release_r9: assert property (@(posedge clk) disable iff (rst)
    (done_i && !done_left_i && pend_q) |=> valid_o);

  // R10: an orphan right word produces nothing
  p_drop_orphan_r10: assert property (@(posedge clk) disable iff (rst)
    (done_i && !done_left_i && !pend_q) |=> !valid_o);

  // R9: outputs move only together with the strobe
  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$stable(left_o) || !$stable(right_o)) |-> valid_o);

endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx #(
  parameter int SAMPLE_W    = 24,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          fmt_i,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                pair_valid_o
);

  logic                rise, lr_s, dat_s;
  logic                done, done_left;
  logic [SAMPLE_W-1:0] word;

  sar_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .bclk_i  (bclk_i),
    .lrclk_i (lrclk_i),
    .sdata_i (sdata_i),
    .rise_o  (rise),
    .lr_o    (lr_s),
    .dat_o   (dat_s)
  );

  sar_frame #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) frame_i (
    .clk         (clk),
    .rst         (rst),
    .fmt_i       (sar_pkg::fmt_e'(fmt_i)),
    .rise_i      (rise),
    .lr_i        (lr_s),
    .dat_i       (dat_s),
    .done_o      (done),
    .done_left_o (done_left),
    .word_o      (word)
  );

  sar_pair #(.SAMPLE_W(SAMPLE_W)) pair_i (
    .clk         (clk),
    .rst         (rst),
    .done_i      (done),
    .done_left_i (done_left),
    .word_i      (word),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (pair_valid_o)
  );

endmodule

// File: tb/ser_audio_rx_tb_top.sv
module ser_audio_rx_tb_top;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [23:0] left_o, right_o;
  logic        pair_valid_o;

  always #5 clk = ~clk;

  ser_audio_rx dut_i (
    .clk (clk), .rst (rst), .fmt_i (fmt),
    .bclk_i (bclk), .lrclk_i (lrclk), .sdata_i (sdata),
    .left_o (left_o), .right_o (right_o), .pair_valid_o (pair_valid_o)
  );

  int checks = 0, errors = 0;
  logic [23:0] got_l [64], got_r [64], exp_l [64], exp_r [64];
  int ngot;
  logic done_flag = 1'b0;

  always @(negedge clk) begin
    if (rst) ngot = 0;
    else if (pair_valid_o) begin
      if (ngot < 64) begin
        got_l[ngot] = left_o;
        got_r[ngot] = right_o;
      end
      ngot++;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic bit_out(input logic lr, input logic d);
    @(negedge clk);
    bclk = 1'b0; lrclk = lr; sdata = d;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic half(input logic lr, input logic [63:0] bits, input int n);
    for (int i = 0; i < n; i++) bit_out(lr, bits[i]);
  endtask

  function automatic logic [63:0] frame_bits(input logic [1:0] f, input logic [23:0] s, input int hlen);
    logic [63:0] b;
    b = {$urandom, $urandom};
    for (int i = 0; i < hlen; i++) begin
      case (f)
        2'b00: if (i < 24) b[i] = s[23-i];
        2'b01: if (i >= 1 && i <= 24) b[i] = s[24-i];
        2'b10: if (i >= hlen-16) b[i] = s[hlen-1-i];
        default: if (i >= hlen-24) b[i] = s[hlen-1-i];
      endcase
    end
    return b;
  endfunction

  function automatic logic [23:0] exp_word(input logic [1:0] f, input logic [23:0] s, input int hlen);
    int nb;
    case (f)
      2'b10: return {{8{s[15]}}, s[15:0]};
      2'b11: return s;
      default: begin
        nb = (f == 2'b00) ? hlen : hlen - 1;
        if (nb > 24) nb = 24;
        return s & (24'hFFFFFF << (24 - nb));
      end
    endcase
  endfunction

  function automatic logic [23:0] pick(input int k);
    case (k)
      0: return 24'h800000;
      1: return 24'h7FFFFF;
      2: return 24'hFFFFFF;
      3: return 24'h000000;
      default: return 24'($urandom);
    endcase
  endfunction

  task automatic run(input logic [1:0] f, input int npairs, input int hlen, input bit orphan, input string tag);
    logic left_lvl;
    logic [23:0] sl, sr;
    rst = 1'b1; fmt = f; bclk = 1'b0;
    repeat (4) @(negedge clk);
    check(pair_valid_o == 1'b0 && left_o == 24'h0 && right_o == 24'h0, "R1 reset",
          {7'b0, pair_valid_o, left_o}, 32'h0);
    rst = 1'b0;
    left_lvl = (f == 2'b01) ? 1'b0 : 1'b1;
    if (orphan) begin
      half(left_lvl, {$urandom, $urandom}, hlen);
      half(~left_lvl, frame_bits(f, 24'hA5A5A5, hlen), hlen);
    end else begin
      half(~left_lvl, {$urandom, $urandom}, hlen);
    end
    for (int k = 0; k < npairs; k++) begin
      sl = pick(k); sr = pick(k + 2);
      exp_l[k] = exp_word(f, sl, hlen);
      exp_r[k] = exp_word(f, sr, hlen);
      half(left_lvl, frame_bits(f, sl, hlen), hlen);
      half(~left_lvl, frame_bits(f, sr, hlen), hlen);
    end
    half(left_lvl, {$urandom, $urandom}, hlen);
    repeat (20) @(negedge clk);
    check(ngot == npairs, {tag, " R9 pair count"}, 32'(ngot), 32'(npairs));
    for (int k = 0; k < npairs && k < ngot; k++) begin
      check(got_l[k] == exp_l[k], {tag, " left"}, {8'h0, got_l[k]}, {8'h0, exp_l[k]});
      check(got_r[k] == exp_r[k], {tag, " right"}, {8'h0, got_r[k]}, {8'h0, exp_r[k]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      finish_up();
    end
  end

  initial begin
    run(2'b00, 8, 32, 1'b0, "R2 R6 R8 left-justified");
    run(2'b01, 8, 32, 1'b0, "R3 R6 R8 I2S");
    run(2'b11, 8, 32, 1'b0, "R4 R6 right-justified 24");
    run(2'b10, 8, 32, 1'b0, "R5 right-justified 16");
    run(2'b00, 6, 16, 1'b0, "R7 left-justified short");
    run(2'b01, 6, 20, 1'b0, "R7 I2S short");
    run(2'b00, 6, 32, 1'b1, "R10 orphan left-justified");
    run(2'b11, 6, 32, 1'b1, "R10 orphan right-justified");
    done_flag = 1'b1;
    finish_up();
  end

endmodule